// File: doc/BRIEF.md
# One-Shot Logic Capture Sampler

This block records the behaviour of one asynchronous digital line as a fixed-length bit trace. The line is first brought into the system clock domain through a chain of flip-flops. After that, one sample is taken on every clock edge, so the sample rate equals the clock rate. Samples are gathered eight at a time into bytes, and each finished byte goes into an on-chip store. There is no gap between bytes.

A capture starts on the first clock edge after reset is released. It ends by itself once the store is full. At that point a done flag rises and nothing more is written. A consumer reads the stored bytes in the order they were captured, through a valid/ready byte port, at whatever pace suits it. It may start reading while the capture is still running. A one-cycle arm pulse throws away the old trace and starts a new capture on the following edge.

The store depth is a parameter. The default is kept small enough for elaboration, and a 16K-byte store is one parameter value away.

Top module: `cap_sampler`

## Requirements
- R1: The line passes through two flip-flops before sampling, so the sample used on clock edge n is the value `din_i` held at edge n-2. Both flip-flops reset to 0.
- R2: Exactly one sample is taken per clock edge while a capture runs. Bytes follow one another with no skipped edges.
- R3: Within a byte, bit 0 holds the earliest sample and bit 7 the latest.
- R4: A byte is written on the edge that takes its eighth sample. The read port therefore first asserts `rd_valid_o` right after the eighth capture edge, and not before.
- R5: `done_o` rises on the edge that writes byte DEPTH-1 (the last store location), which is capture edge 8*DEPTH-1. It is low on every edge before that.
- R6: Once `done_o` is high, no further byte is written, whatever `din_i` does. Exactly DEPTH bytes can be read, and their contents do not change.
- R7: The read port returns bytes in capture order. A byte is consumed on an edge where `rd_valid_o` and `rd_ready_i` are both high. `rd_valid_o` falls once every written byte has been read, and reads running during a capture never pass the write position.
- R8: A high `arm_i` on an edge clears the write and read positions, the bit position and `done_o`. The new capture's first sample is taken on the next edge, always as bit 0 of a fresh byte.
- R9: While `rst_ni` is low, `done_o` and `rd_valid_o` are low. The first capture edge is the first edge after `rst_ni` rises.
- R10: A high `rd_ready_i` while `rd_valid_o` is low has no effect. The first byte read after such a period is still byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 1 | Asynchronous line to capture |
| arm_i | input | 1 | Discard trace and restart capture |
| rd_ready_i | input | 1 | Consumer accepts the presented byte |
| rd_valid_o | output | 1 | A captured byte is presented |
| rd_data_o | output | 8 | Presented byte, earliest sample in bit 0 |
| done_o | output | 1 | Store full; capture stopped |

## Verification
The line is driven with a serialized table of bytes that mixes all-zero and all-one runs, alternating bits, nibble steps and lone single bits. This separates errors in bit order and in the two-edge synchronizer latency from errors that only show as a shifted byte boundary. A second capture is read out while it is still being written, with ready held high from the start, which exercises readout that keeps pace with the writer and the empty-port case. A third capture is re-armed in the middle of a byte, which shows whether the bit position really returns to zero. The done edge, the first-valid edge and the halt after done are each checked on the exact cycle where they are due.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int unsigned WORD_W = 8;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/cap_packer.sv
module cap_packer #(
  parameter  int unsigned W  = 8,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         sample_i,
  output logic         wr_o,
  output logic [W-1:0] word_o
);
  logic [CW-1:0] cnt_q;
  logic [W-2:0]  sh_q;
  logic          last;

  assign last   = (cnt_q == CW'(W-1));
  assign wr_o   = en_i && !clr_i && last;
  // last sample bypasses the register so the word is written on its own edge
  assign word_o = {sample_i, sh_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (last) begin
        cnt_q <= '0;
      end else begin
        sh_q[cnt_q] <= sample_i;
        cnt_q       <= cnt_q + 1'b1;
      end
    end
  end

  // R4: word writes are never on adjacent edges
  a_r4_write_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);
endmodule

// File: rtl/cap_store.sv
module cap_store #(
  parameter  int unsigned DEPTH = 2048,
  parameter  int unsigned W     = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = AW + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         arm_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_ready_i,
  output logic         rd_valid_o,
  output logic [W-1:0] rd_data_o,
  output logic         done_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic          done_q;
  logic          wr_en, rd_fire;

  assign wr_en      = wr_i && !done_q && !arm_i;
  assign rd_valid_o = (rptr_q != wptr_q);
  assign rd_fire    = rd_valid_o && rd_ready_i && !arm_i;
  assign rd_data_o  = mem_q[rptr_q[AW-1:0]];
  assign done_o     = done_q;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wptr_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      done_q <= 1'b0;
    end else if (arm_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (wr_en) begin
        wptr_q <= wptr_q + 1'b1;
        if (wptr_q == PW'(DEPTH-1)) done_q <= 1'b1;
      end
      if (rd_fire) rptr_q <= rptr_q + 1'b1;
    end
  end

  // R5: done rises only with the store full
  a_r5_done_at_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> (wptr_q == PW'(DEPTH)));
  // R6: no write position movement once done, unless re-armed
  a_r6_halt_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !arm_i) |=> $stable(wptr_q));
  // R7: reader never passes the writer
  a_r7_no_overread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rptr_q <= wptr_q);
  // R8: arm empties the store and clears done
  a_r8_arm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (wptr_q == '0 && rptr_q == '0 && !done_q));
endmodule

// File: rtl/cap_sampler.sv
module cap_sampler
  import cap_pkg::*;
#(
  parameter int unsigned DEPTH       = 2048,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  din_i,
  input  logic  arm_i,
  input  logic  rd_ready_i,
  output logic  rd_valid_o,
  output word_t rd_data_o,
  output logic  done_o
);
  logic  sample;
  logic  wr;
  word_t word;

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (din_i),
    .q_o   (sample)
  );

  cap_packer #(.W(WORD_W)) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (arm_i),
    .en_i    (!done_o),
    .sample_i(sample),
    .wr_o    (wr),
    .word_o  (word)
  );

  cap_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm_i),
    .wr_i      (wr),
    .wdata_i   (word),
    .rd_ready_i(rd_ready_i),
    .rd_valid_o(rd_valid_o),
    .rd_data_o (rd_data_o),
    .done_o    (done_o)
  );
endmodule

// File: tb/sim_cap_sampler.sv
module sim_cap_sampler;
  localparam int DEPTH = 16;
  localparam int CYC   = 8 * DEPTH;
  localparam logic [7:0] PAT [16] = '{
    8'h00, 8'hFF, 8'hAA, 8'h55, 8'h0F, 8'hF0, 8'h01, 8'h80,
    8'h3C, 8'hC3, 8'h7E, 8'h81, 8'h12, 8'hED, 8'h66, 8'h99};

  logic       clk = 1'b0, rst_ni = 1'b0, din_i = 1'b0, arm_i = 1'b0, rd_ready_i = 1'b0;
  logic       rd_valid_o, done_o;
  logic [7:0] rd_data_o;

  int   n_run = 0, n_fail = 0, cur = 0, s = 0, rcnt = 0, first_k = -1;
  logic hist [4096];

  always #5 clk = ~clk;

  cap_sampler #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .din_i(din_i), .arm_i(arm_i),
    .rd_ready_i(rd_ready_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .done_o(done_o));

  // drive before edge `cur`, then sample 1 ns after that edge
  task automatic tick(input bit rn, input bit d, input bit a, input bit r);
    @(negedge clk);
    rst_ni = rn; din_i = d; arm_i = a; rd_ready_i = r;
    hist[cur] = d;
    cur++;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bit b of byte j of a capture starting at edge st: line value two edges earlier
  function automatic logic [7:0] exp_byte(input int st, input int j);
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[b] = hist[st + 8*j + b - 2];
    return v;
  endfunction

  function automatic bit pbit(input int k);
    return PAT[(k/8) % 16][k % 8];
  endfunction

  initial begin
    for (int i = 0; i < 4096; i++) hist[i] = 1'b0;
    // R9: reset state
    for (int i = 0; i < 4; i++) tick(0, 0, 0, 0);
    chk("R9 done in reset", int'(done_o), 0);
    chk("R9 valid in reset", int'(rd_valid_o), 0);

    // capture from reset, ready low
    s = cur;
    for (int k = 0; k < CYC; k++) begin
      tick(1, pbit(k), 0, 0);
      if (k == 6)       chk("R4 no valid before 8th edge", int'(rd_valid_o), 0);
      if (k == 7)       chk("R4 valid after 8th edge", int'(rd_valid_o), 1);
      if (k == CYC - 2) chk("R5 done not early", int'(done_o), 0);
      if (k == CYC - 1) chk("R5 done on last write", int'(done_o), 1);
    end
    for (int k = 0; k < 40; k++) tick(1, k[0] ^ k[2], 0, 0);
    chk("R6 done held", int'(done_o), 1);
    // table walk: R1 R2 R3 R6 R7 readout in order
    for (int j = 0; j < DEPTH; j++) begin
      chk("R7 valid during readout", int'(rd_valid_o), 1);
      chk("R3 R1 R2 byte content", int'(rd_data_o), int'(exp_byte(s, j)));
      tick(1, j[0], 0, 1);
    end
    chk("R6 R7 valid low after DEPTH reads", int'(rd_valid_o), 0);
    tick(1, 1, 0, 1);
    tick(1, 0, 0, 1);
    chk("R7 no read past writer", int'(rd_valid_o), 0);

    // R8 R10: re-arm from done, ready held high, read during capture
    tick(1, 0, 1, 1);
    s = cur;
    chk("R8 done cleared by arm", int'(done_o), 0);
    chk("R8 valid cleared by arm", int'(rd_valid_o), 0);
    rcnt = 0;
    for (int k = 0; k < CYC + 4; k++) begin
      if (rd_valid_o) begin
        if (first_k < 0) first_k = k;
        chk("R10 R7 concurrent byte", int'(rd_data_o), int'(exp_byte(s, rcnt)));
        rcnt++;
      end
      tick(1, pbit(3*k + 5), 0, 1);
    end
    chk("R4 first byte seen after 8th edge", first_k, 8);
    chk("R7 all bytes read concurrently", rcnt, DEPTH);
    chk("R5 done after concurrent capture", int'(done_o), 1);

    // R8: re-arm mid-byte, bit position must restart
    tick(1, 0, 1, 0);
    for (int k = 0; k < 20; k++) tick(1, pbit(k + 11), 0, 0);
    tick(1, 1, 1, 0);
    s = cur;
    chk("R8 valid cleared mid capture", int'(rd_valid_o), 0);
    chk("R8 done low mid capture", int'(done_o), 0);
    for (int k = 0; k < CYC; k++) begin
      tick(1, pbit(k + 37), 0, 0);
      if (k == CYC - 2) chk("R8 R5 done not early after rearm", int'(done_o), 0);
      if (k == CYC - 1) chk("R8 R5 done after rearm", int'(done_o), 1);
    end
    for (int j = 0; j < DEPTH; j++) begin
      chk("R8 byte alignment after rearm", int'(rd_data_o), int'(exp_byte(s, j)));
      tick(1, 0, 0, 1);
    end
    chk("R8 valid low after readout", int'(rd_valid_o), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule